// File: doc/BRIEF.md
# Programmable Prescaled Interval Timer

This block is a byte-addressed timer peripheral for a small 8-bit processor system. A 16-bit divider counts every system clock, and software can read its upper byte. An 8-bit interval counter steps at one of four rates taken from taps of that divider. When the interval counter steps past 0xFF, it reloads from a programmable modulo register and emits a one-cycle interrupt request.

Software selects the rate and enables the counter through a 3-bit control register. It sets the period through the modulo register and may load the counter directly. Register reads are combinational in the cycle the read strobe is high. Writes take effect at the next clock edge.

Top module: `ivl_timer`

## Requirements
- R1: The 16-bit divider increases by one on every clock edge that is not a divider write, wrapping from 0xFFFF to 0x0000.
- R2: A write to offset 0 clears the whole divider to zero at that edge, whatever the write data.
- R3: A read of offset 0 returns divider bits 15:8; a read returns data in the same cycle that `bus_rd` is high, and `bus_rdata` is 0 when `bus_rd` is low.
- R4: Control bits 1:0 pick the divider tap: 00 bit 9 (1024 clocks), 01 bit 3 (16), 10 bit 5 (64), 11 bit 7 (256). When the tapped bit reads 1 in one cycle and 0 in the next, the counter steps at the following edge. A divider clear that drops the tapped bit also counts as a step.
- R5: With control bit 2 clear, the interval counter holds its value (writes excepted) while the divider keeps running.
- R6: A step from 0xFF loads the counter with the modulo register value held before that edge, never with zero.
- R7: `irq_pulse` is high for exactly one cycle, the first cycle in which the counter holds the reloaded value.
- R8: A write to offset 1 loads the counter and replaces a step in the same cycle; a reload from overflow in the same cycle wins over the write.
- R9: The modulo register (offset 2, 8 bits) and control register (offset 3, bits 2:0) read back what was written; control read bits 7:3 are always 1 and writes to them are ignored.
- R10: After reset, divider, counter, modulo and control are zero, `irq_pulse` is low, and control reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 divider, 1 counter, 2 modulo, 3 control |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq_pulse | output | 1 | One-cycle timer interrupt request |

## Verification
A processor write to the interval counter and an overflow reload can land on the same clock edge. The same holds for a modulo write and a reload. The bench locates those edges from its reference model, which predicts when the next edge will carry a tap fall with the counter at 0xFF, and it issues the write in exactly that cycle. It then checks that the counter reads back the old modulo value and that the interrupt pulse still fires. It also times a counter write onto an ordinary step edge to confirm that the written value is kept without the increment.

// File: rtl/tmr_pkg.sv
// Shared definitions for the interval timer: register offsets and tap lookup.
// Assumes a divider of at least 10 bits so the slowest tap exists.
package tmr_pkg;

    typedef enum logic [1:0] {
        OFS_DIV = 2'd0,
        OFS_CNT = 2'd1,
        OFS_MOD = 2'd2,
        OFS_CTL = 2'd3
    } reg_ofs_e;

    localparam int CTL_W = 3;

    // Map the 2-bit rate select onto the divider bit whose fall marks a step.
    function automatic logic [3:0] rate_tap(input logic [1:0] sel);
        logic [3:0] tap;
        case (sel)
            2'b00:   tap = 4'd9;
            2'b01:   tap = 4'd3;
            2'b10:   tap = 4'd5;
            default: tap = 4'd7;
        endcase
        return tap;
    endfunction

endpackage

// File: rtl/tmr_divider.sv
// Free-running divider. Counts every clock; a clear request zeroes it.
// Assumes clear is a single-cycle qualified write strobe.
module tmr_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count_q
);
    // Count up, or zero on a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (clear) count_q <= '0;
        else            count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/tmr_tick_gen.sv
// Step generator: watches the divider bit picked by the rate select and
// flags a step in the cycle after that bit goes from 1 to 0, when enabled.
// Assumes the divider is wide enough to hold tap index 9.
module tmr_tick_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_q,
    input  logic [1:0]   rate_sel,
    input  logic         enable,
    output logic         tick
);
    import tmr_pkg::*;

    logic [3:0] tap;
    logic       tap_now;
    logic       tap_prev_q;

    // Pick the tapped divider bit for the current rate.
    always_comb begin
        tap     = rate_tap(rate_sel);
        tap_now = div_q[tap];
    end

    // Remember the tapped bit from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_prev_q <= 1'b0;
        else        tap_prev_q <= tap_now;
    end

    // A 1-to-0 transition of the tap is a step when the counter is enabled.
    assign tick = enable & tap_prev_q & ~tap_now;
endmodule

// File: rtl/tmr_counter.sv
// Interval counter with modulo reload and interrupt pulse.
// Priority at an edge: overflow reload, then processor write, then step.
// The interrupt pulse is registered so it aligns with the reloaded value.
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt_q,
    output logic         ovf,
    output logic         irq_q
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // An overflow is a step taken while the counter is at its maximum.
    assign ovf = tick && (cnt_q == CNT_MAX);

    // Update the counter by priority: reload, write, step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (ovf)   cnt_q <= reload_val;
        else if (wr_en) cnt_q <= wr_data;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

    // Pulse the interrupt for the one cycle after a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ovf;
    end
endmodule

// File: rtl/ivl_timer.sv
// Top of the prescaled interval timer: register decode, modulo and control
// storage, read mux, and the divider / step / counter datapath.
// Assumes a single-master byte bus with one strobe active per cycle.
module ivl_timer #(
    parameter int DIV_W = 16,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DAT_W-1:0] bus_wdata,
    output logic [DAT_W-1:0] bus_rdata,
    output logic             irq_pulse
);
    import tmr_pkg::*;

    localparam int CTL_PAD = DAT_W - CTL_W;

    logic [DIV_W-1:0] div_q;
    logic [DAT_W-1:0] cnt_q;
    logic [DAT_W-1:0] tma_q;
    logic [CTL_W-1:0] ctl_q;
    logic             tick;
    logic             ovf;
    logic             wr_div, wr_cnt, wr_mod, wr_ctl;
    logic             unused_wdata_hi;

    // Decode write strobes per register.
    always_comb begin
        wr_div = bus_wr && (bus_addr == OFS_DIV);
        wr_cnt = bus_wr && (bus_addr == OFS_CNT);
        wr_mod = bus_wr && (bus_addr == OFS_MOD);
        wr_ctl = bus_wr && (bus_addr == OFS_CTL);
    end

    assign unused_wdata_hi = ^bus_wdata[DAT_W-1:CTL_W];

    // Hold the modulo and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tma_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_mod) tma_q <= bus_wdata;
            if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
        end
    end

    tmr_divider #(.W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wr_div),
        .count_q (div_q)
    );

    tmr_tick_gen #(.W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_q    (div_q),
        .rate_sel (ctl_q[1:0]),
        .enable   (ctl_q[2]),
        .tick     (tick)
    );

    tmr_counter #(.W(DAT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_cnt),
        .wr_data    (bus_wdata),
        .reload_val (tma_q),
        .cnt_q      (cnt_q),
        .ovf        (ovf),
        .irq_q      (irq_pulse)
    );

    // Select read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_DIV: bus_rdata = div_q[DIV_W-1 -: DAT_W];
                OFS_CNT: bus_rdata = cnt_q;
                OFS_MOD: bus_rdata = tma_q;
                default: bus_rdata = {{CTL_PAD{1'b1}}, ctl_q};
            endcase
        end
    end
endmodule

// File: rtl/tmr_checker.sv
// Property checker for ivl_timer, attached by bind. Observes ports and the
// registers that the separate submodules drive.
module tmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        irq_pulse,
    input logic [15:0] div_q,
    input logic [7:0]  cnt_q,
    input logic [7:0]  tma_q,
    input logic [2:0]  ctl_q,
    input logic        ovf
);
    // R1
    div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) |=> div_q == $past(div_q) + 16'd1);

    // R2
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> div_q == 16'd0);

    // R5
    hold_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[2] && !(bus_wr && bus_addr == 2'd1)) |=> $stable(cnt_q));

    // R6
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt_q == $past(tma_q));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R8
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !ovf) |=> cnt_q == $past(bus_wdata));

    // R9
    ctl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |-> bus_rdata[7:3] == 5'b11111);
endmodule

bind ivl_timer tmr_checker u_tmr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse),
    .div_q     (div_q),
    .cnt_q     (cnt_q),
    .tma_q     (tma_q),
    .ctl_q     (ctl_q),
    .ovf       (ovf)
);

// File: tb/test_ivl_timer.sv
// Bench for ivl_timer: a behavioural reference model advanced on every
// rising edge, compared against the outputs shortly after each falling edge.
module test_ivl_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int n_collide = 0;
    string tag = "R10";
    bit live = 1'b0;

    // reference model state
    int m_div = 0, m_cnt = 0, m_mod = 0, m_ctl = 0;
    bit m_prev = 1'b0, m_irq = 1'b0;

    ivl_timer i_ivl_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    always #4 clk = ~clk;

    function automatic int tap_of(int ctl);
        int period;
        case (ctl % 4)
            0: period = 1024;
            1: period = 16;
            2: period = 64;
            default: period = 256;
        endcase
        return $clog2(period) - 1;
    endfunction

    function automatic bit tap_bit();
        return ((m_div >> tap_of(m_ctl)) & 1) != 0;
    endfunction

    function automatic bit step_next();
        return ((m_ctl & 4) != 0) && m_prev && !tap_bit();
    endfunction

    function automatic bit ovf_next();
        return step_next() && (m_cnt == 255);
    endfunction

    function automatic int exp_rdata();
        if (!bus_rd) return 0;
        case (bus_addr)
            2'd0: return (m_div >> 8) & 255;
            2'd1: return m_cnt;
            2'd2: return m_mod;
            default: return 248 | m_ctl;
        endcase
    endfunction

    // Advance the reference model at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_mod = 0; m_ctl = 0;
            m_prev = 0; m_irq = 0;
        end else begin
            bit st, ov;
            st = step_next();
            ov = st && (m_cnt == 255);
            m_irq = ov;
            m_prev = tap_bit();
            if (ov) m_cnt = m_mod;
            else if (bus_wr && bus_addr == 2'd1) m_cnt = bus_wdata;
            else if (st) m_cnt = (m_cnt + 1) & 255;
            if (bus_wr && bus_addr == 2'd0) m_div = 0;
            else m_div = (m_div + 1) & 16'hFFFF;
            if (bus_wr && bus_addr == 2'd2) m_mod = bus_wdata;
            if (bus_wr && bus_addr == 2'd3) m_ctl = bus_wdata & 7;
        end
    end

    task automatic compare();
        n_cmp++;
        if (irq_pulse !== m_irq) begin
            n_bad++;
            $display("FAIL %s irq_pulse actual=%0b expected=%0b", tag, irq_pulse, m_irq);
        end
        n_cmp++;
        if (bus_rdata !== 8'(exp_rdata())) begin
            n_bad++;
            $display("FAIL %s rdata@%0d actual=%02h expected=%02h", tag, bus_addr,
                     bus_rdata, exp_rdata());
        end
    endtask

    // One bus cycle: drive, settle, compare, move to the next falling edge.
    task automatic cyc(bit wr, bit rd, logic [1:0] a, logic [7:0] d);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        if (live) compare();
        @(negedge clk);
    endtask

    task automatic run_rd(int n, logic [1:0] a);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic plain(string t, bit ok, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R10: reset state, fixed values too
        tag = "R10";
        bus_rd = 1'b1; bus_addr = 2'd3; #1;
        plain("R10 ctl reset read", bus_rdata == 8'hF8, bus_rdata, 8'hF8);
        plain("R10 irq reset", irq_pulse == 1'b0, irq_pulse, 0);
        @(negedge clk);
        run_rd(1, 2'd1); run_rd(1, 2'd2); run_rd(1, 2'd3); run_rd(1, 2'd0);
        // R9: modulo and control storage, upper control bits ignored
        tag = "R9";
        wr(2'd2, 8'hA5); wr(2'd3, 8'h02);
        run_rd(2, 2'd2); run_rd(2, 2'd3);
        wr(2'd3, 8'h00);
        // R1, R3: divider runs, upper byte readable
        tag = "R1_R3";
        run_rd(600, 2'd0);
        // R2: clear with arbitrary data
        tag = "R2";
        wr(2'd0, 8'h5A);
        run_rd(300, 2'd0);
        // R4, R6, R7: every rate, overflow and reload
        for (int s = 0; s < 4; s++) begin
            int sel;
            sel = (s + 1) % 4;
            tag = "R4_R6_R7";
            wr(2'd2, 8'(8'hF0 + s));
            wr(2'd1, 8'hFD);
            wr(2'd3, 8'(4 | sel));
            run_rd(5 * (1 << (tap_of(sel) + 1)), 2'd1);
        end
        // R5: disabled counter holds, divider keeps running
        tag = "R5";
        wr(2'd3, 8'h01);
        wr(2'd1, 8'h40);
        run_rd(200, 2'd1);
        run_rd(100, 2'd0);
        // R8: write on an ordinary step edge keeps the written value
        tag = "R8";
        wr(2'd1, 8'h10); wr(2'd3, 8'h05);
        for (int i = 0; i < 100; i++) begin
            if (step_next() && m_cnt != 255) begin
                wr(2'd1, 8'h77);
                n_collide++;
                break;
            end
            run_rd(1, 2'd1);
        end
        run_rd(3, 2'd1);
        // R8: counter write collides with overflow reload
        wr(2'd2, 8'h3C); wr(2'd1, 8'hFE);
        for (int i = 0; i < 100; i++) begin
            if (ovf_next()) begin
                wr(2'd1, 8'h99);
                n_collide++;
                break;
            end
            run_rd(1, 2'd1);
        end
        run_rd(4, 2'd1);
        // R6: modulo write in the reload cycle; reload uses the old value
        tag = "R6";
        wr(2'd1, 8'hFE);
        for (int i = 0; i < 100; i++) begin
            if (ovf_next()) begin
                wr(2'd2, 8'h11);
                n_collide++;
                break;
            end
            run_rd(1, 2'd1);
        end
        run_rd(4, 2'd1);
        run_rd(1, 2'd2);
        plain("R8 R6 collisions provoked", n_collide == 3, n_collide, 3);
        // R4: divider clear drops the tap and counts as a step
        tag = "R4";
        run_rd(12, 2'd1);
        wr(2'd0, 8'h00);
        run_rd(40, 2'd1);
        live = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule